// File: doc/BRIEF.md
# Tree-Reduction Operand Schedule Generator

This block produces, one entry at a time, the operand indices for an in-place tree reduction over a vector of `len` elements. The length need not be a power of two. The schedule runs in levels. At each level the pair stride doubles. At the level whose half-stride is `h`, every slot `i` that is a multiple of `2h` is paired with slot `i+h`, provided that slot is inside the vector. A pair produces an operation only when both slots currently hold a live value. An element predicate mask is captured at configuration time. It is indexed by remapped element position, so it applies after the element order has been remapped.

No data moves are ever scheduled. Each slot keeps a tracked position: the element position where its partial result currently lives. Suppose a slot is dead but its partner is live. The slot then adopts the partner's tracked position and becomes live, so later levels source the surviving value from where it already sits. A single select bit chooses which operand index the output carries: the left (destination) one or the right one. Two instances configured identically except for this bit give two aligned operand streams. A base offset is added to every index.

A consumer loads a configuration and then takes each entry it sees by pulsing an advance input. Each entry carries end flags that mark the last operation of a level and of the final level. A one-cycle done indication follows the final level. The same schedule then starts again from its initial state.

Top module: `tree_reduce_sched`

## Requirements
- R1: After reset, and until the first configuration load, `valid_o`, `done_o`, `end_o` and `idx_o` are all 0, and `adv_i` has no effect.
- R2: The levels use half-strides h = 1, 2, 4, … for as long as h < len. Within a level, the candidate slots i = 0, 2h, 4h, … are visited in ascending order, and the partner of slot i is slot i+h. A pair is considered only when i+h < len.
- R3: The predicate is sampled at configuration load. Bit p of `cfg_pred_i` refers to remapped element position p. A pair emits an entry only when the predicate bits at the tracked positions of both its slots are 1.
- R4: With `cfg_sel_right_i`=0, `idx_o` is the tracked position of slot i plus the offset. With `cfg_sel_right_i`=1, it is the tracked position of slot i+h plus the offset. The sum wraps modulo 2^OUT_W.
- R5: When slot i is dead and slot i+h is live, no entry is emitted. Slot i takes the tracked position of slot i+h and is live from the next level onward.
- R6: `end_o` is 2'b00 except on the last entry of a level, where it is 2'b01. On the last entry of the final level in schedule order, it is 2'b11. A level that emits nothing marks nothing. `end_o` is 0 whenever `valid_o` is 0.
- R7: With `cfg_rev_elem_i`=1, the initial tracked position of slot e is len-1-e instead of e.
- R8: With `cfg_rev_level_i`=1, the levels run from the largest half-stride down to 1.
- R9: An entry stays on `idx_o`/`end_o`, with `valid_o`=1, until `adv_i` is sampled high. One entry is consumed per such cycle. `adv_i` has no effect while `valid_o` is 0.
- R10: After the final level, `done_o` is high for exactly one cycle. The schedule then restarts from its initial tracked state and reproduces the same entries.
- R11: Lengths of 0 and 1 emit no entries and only cycle `done_o`. Lengths above MAX_LEN are clamped. At most MAX_LEN-1 entries (127 by default) are emitted per pass.
- R12: A configuration load in any state abandons the current schedule. `valid_o` and `done_o` are low in the following cycle, and the new schedule starts from its beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Capture configuration and restart |
| cfg_len_i | input | LEN_W (8) | Number of elements |
| cfg_pred_i | input | MAX_LEN (128) | Predicate by remapped element position |
| cfg_rev_elem_i | input | 1 | Reverse the element order |
| cfg_rev_level_i | input | 1 | Reverse the level order |
| cfg_sel_right_i | input | 1 | 0: left operand index, 1: right operand index |
| cfg_offset_i | input | OUT_W (8) | Base offset added to each index |
| adv_i | input | 1 | Consume the presented entry |
| valid_o | output | 1 | An entry is presented |
| idx_o | output | OUT_W (8) | Operand index plus offset |
| end_o | output | 2 | {final-level end, level end} |
| done_o | output | 1 | One-cycle pulse after the final level |

## Verification
The tracking table is the hidden state. A corrupted tracked position does not show on the entry that caused it. It shows on the first later-level entry that sources that slot, which is usually within the next level. A wrong live bit shows sooner, as an entry that is missing or extra within the same level. This also shifts every later `end_o` flag and changes the entry count at `done_o`. For this reason, each pass is checked entry by entry and also by its length, and runs a second pass after done to expose state that a restart fails to reinitialise. A wrong level counter shows at once in the stride of the next entry and in `end_o[1]`.

// File: rtl/tree_reduce_pkg.sv
package tree_reduce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SEARCH,
    ST_HOLD,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/tree_reduce_track.sv
// Per-slot tracked position and live bit; merges applied at level end
module tree_reduce_track #(
  parameter int N     = 128,
  parameter int IW    = 7,
  parameter int LEN_W = 8,
  parameter int KW    = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   init_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic                   rev_i,
  input  logic [N-1:0]           pred_i,
  input  logic                   merge_i,
  input  logic [N-1:0]           merge_vec_i,
  input  logic [KW-1:0]          k_i,
  output logic [N-1:0][IW-1:0]   ix_o,
  output logic [N-1:0]           live_o
);
  logic [N-1:0][IW-1:0] ix_q, init_ix, merge_ix;
  logic [N-1:0]         live_q, init_live;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      int b;
      int src;
      b = e;
      if (rev_i && e < int'(len_i)) b = int'(len_i) - 1 - e;
      init_ix[e]   = IW'(b);
      init_live[e] = (e < int'(len_i)) && pred_i[b];
      src = e + (1 << int'(k_i));
      if (src >= N) src = e;
      merge_ix[e] = merge_vec_i[e] ? ix_q[src] : ix_q[e];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ix_q   <= '0;
      live_q <= '0;
    end else if (init_i) begin
      ix_q   <= init_ix;
      live_q <= init_live;
    end else if (merge_i) begin
      ix_q   <= merge_ix;
      live_q <= live_q | merge_vec_i;
    end
  end

  assign ix_o   = ix_q;
  assign live_o = live_q;
endmodule

// File: rtl/tree_reduce_pairs.sv
// Combinational pair finder for one level
module tree_reduce_pairs #(
  parameter int N     = 128,
  parameter int IW    = 7,
  parameter int LEN_W = 8,
  parameter int KW    = 3
) (
  input  logic [N-1:0]     live_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [KW-1:0]    k_i,
  input  logic [IW-1:0]    pos_i,
  output logic [N-1:0]     merge_vec_o,
  output logic             first_any_o,
  output logic [IW-1:0]    first_idx_o,
  output logic             next_any_o,
  output logic [IW-1:0]    next_idx_o
);
  logic [N-1:0] emit;

  always_comb begin
    int half;
    int step;
    half = 1 << int'(k_i);
    step = half << 1;
    for (int j = 0; j < N; j++) begin
      int  par;
      logic in_lvl, pl;
      par    = j + half;
      in_lvl = (j & (step - 1)) == 0;
      pl     = (par < int'(len_i)) && (par < N) && live_i[(par < N) ? par : j];
      emit[j]        = in_lvl && pl && live_i[j];
      merge_vec_o[j] = in_lvl && pl && !live_i[j];
    end
  end

  always_comb begin
    first_any_o = 1'b0;
    first_idx_o = '0;
    next_any_o  = 1'b0;
    next_idx_o  = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (emit[j]) begin
        first_any_o = 1'b1;
        first_idx_o = IW'(j);
        if (j > int'(pos_i)) begin
          next_any_o = 1'b1;
          next_idx_o = IW'(j);
        end
      end
    end
  end
endmodule

// File: rtl/tree_reduce_ctrl.sv
module tree_reduce_ctrl
  import tree_reduce_pkg::*;
#(
  parameter int IW = 7,
  parameter int KW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_load_i,
  input  logic          adv_i,
  input  logic [KW-1:0] nlev_i,
  input  logic          first_any_i,
  input  logic [IW-1:0] first_idx_i,
  input  logic          next_any_i,
  input  logic [IW-1:0] next_idx_i,
  output logic [KW-1:0] lvl_o,
  output logic [IW-1:0] pos_o,
  output logic          last_lvl_o,
  output logic          init_o,
  output logic          merge_o,
  output logic          hold_o,
  output logic          done_o
);
  seq_state_e    state_q;
  logic [KW-1:0] lvl_q;
  logic [IW-1:0] pos_q;
  logic          last_lvl, level_over;

  assign last_lvl   = (lvl_q == nlev_i - KW'(1));
  assign level_over = ((state_q == ST_SEARCH) && !first_any_i) ||
                      ((state_q == ST_HOLD) && adv_i && !next_any_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      pos_q   <= '0;
    end else if (cfg_load_i) begin
      state_q <= ST_INIT;
      lvl_q   <= '0;
      pos_q   <= '0;
    end else begin
      case (state_q)
        ST_INIT: begin
          lvl_q   <= '0;
          state_q <= (nlev_i == '0) ? ST_DONE : ST_SEARCH;
        end
        ST_SEARCH: begin
          if (first_any_i) begin
            pos_q   <= first_idx_i;
            state_q <= ST_HOLD;
          end else if (last_lvl) begin
            state_q <= ST_DONE;
          end else begin
            lvl_q <= lvl_q + KW'(1);
          end
        end
        ST_HOLD: begin
          if (adv_i) begin
            if (next_any_i) begin
              pos_q <= next_idx_i;
            end else if (last_lvl) begin
              state_q <= ST_DONE;
            end else begin
              lvl_q   <= lvl_q + KW'(1);
              state_q <= ST_SEARCH;
            end
          end
        end
        ST_DONE: state_q <= ST_INIT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lvl_o      = lvl_q;
  assign pos_o      = pos_q;
  assign last_lvl_o = last_lvl;
  assign init_o     = (state_q == ST_INIT);
  assign merge_o    = level_over && !cfg_load_i;
  assign hold_o     = (state_q == ST_HOLD);
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/tree_reduce_sched.sv
// Tree-reduction operand schedule generator (MAX_LEN must be a power of two)
module tree_reduce_sched #(
  parameter int MAX_LEN = 128,
  parameter int OUT_W   = 8,
  localparam int IW     = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int KW     = $clog2(IW + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_load_i,
  input  logic [LEN_W-1:0]   cfg_len_i,
  input  logic [MAX_LEN-1:0] cfg_pred_i,
  input  logic               cfg_rev_elem_i,
  input  logic               cfg_rev_level_i,
  input  logic               cfg_sel_right_i,
  input  logic [OUT_W-1:0]   cfg_offset_i,
  input  logic               adv_i,
  output logic               valid_o,
  output logic [OUT_W-1:0]   idx_o,
  output logic [1:0]         end_o,
  output logic               done_o
);
  logic [LEN_W-1:0]   len_q;
  logic [MAX_LEN-1:0] pred_q;
  logic               rev_elem_q, rev_lvl_q, sel_q;
  logic [OUT_W-1:0]   off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q      <= '0;
      pred_q     <= '0;
      rev_elem_q <= 1'b0;
      rev_lvl_q  <= 1'b0;
      sel_q      <= 1'b0;
      off_q      <= '0;
    end else if (cfg_load_i) begin
      len_q      <= (int'(cfg_len_i) > MAX_LEN) ? LEN_W'(MAX_LEN) : cfg_len_i;
      pred_q     <= cfg_pred_i;
      rev_elem_q <= cfg_rev_elem_i;
      rev_lvl_q  <= cfg_rev_level_i;
      sel_q      <= cfg_sel_right_i;
      off_q      <= cfg_offset_i;
    end
  end

  // number of levels: count of h=2^k with h < len
  logic [KW-1:0] nlev, lvl, k_cur;
  always_comb begin
    nlev = '0;
    for (int k = 0; k < IW; k++)
      if ((1 << k) < int'(len_q)) nlev = nlev + KW'(1);
  end
  assign k_cur = rev_lvl_q ? (nlev - KW'(1) - lvl) : lvl;

  logic [MAX_LEN-1:0][IW-1:0] ix_vec;
  logic [MAX_LEN-1:0]         live_vec, merge_vec;
  logic                       first_any, next_any, init, merge, hold, last_lvl;
  logic [IW-1:0]              first_idx, next_idx, pos;

  tree_reduce_track #(.N(MAX_LEN), .IW(IW), .LEN_W(LEN_W), .KW(KW)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init),
    .len_i       (len_q),
    .rev_i       (rev_elem_q),
    .pred_i      (pred_q),
    .merge_i     (merge),
    .merge_vec_i (merge_vec),
    .k_i         (k_cur),
    .ix_o        (ix_vec),
    .live_o      (live_vec)
  );

  tree_reduce_pairs #(.N(MAX_LEN), .IW(IW), .LEN_W(LEN_W), .KW(KW)) u_pairs (
    .live_i      (live_vec),
    .len_i       (len_q),
    .k_i         (k_cur),
    .pos_i       (pos),
    .merge_vec_o (merge_vec),
    .first_any_o (first_any),
    .first_idx_o (first_idx),
    .next_any_o  (next_any),
    .next_idx_o  (next_idx)
  );

  tree_reduce_ctrl #(.IW(IW), .KW(KW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_load_i  (cfg_load_i),
    .adv_i       (adv_i),
    .nlev_i      (nlev),
    .first_any_i (first_any),
    .first_idx_i (first_idx),
    .next_any_i  (next_any),
    .next_idx_i  (next_idx),
    .lvl_o       (lvl),
    .pos_o       (pos),
    .last_lvl_o  (last_lvl),
    .init_o      (init),
    .merge_o     (merge),
    .hold_o      (hold),
    .done_o      (done_o)
  );

  logic [IW-1:0] pick;
  always_comb begin
    int p;
    p = int'(pos) + (1 << int'(k_cur));
    if (p >= MAX_LEN) p = int'(pos);
    pick = sel_q ? ix_vec[p] : ix_vec[pos];
  end

  assign valid_o = hold;
  assign idx_o   = hold ? (off_q + OUT_W'(pick)) : '0;
  assign end_o   = hold ? {last_lvl && !next_any, !next_any} : 2'b00;
endmodule

// File: rtl/tree_reduce_sched_chk.sv
module tree_reduce_sched_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_load_i,
  input logic             adv_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] idx_o,
  input logic [1:0]       end_o,
  input logic             done_o
);
  p_valid_done_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && done_o));

  p_end_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> end_o == 2'b00);

  p_end_nested_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o[1] |-> end_o[0]);

  p_hold_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !adv_i && !cfg_load_i |=> valid_o && $stable(idx_o) && $stable(end_o));

  p_load_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> !valid_o && !done_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !cfg_load_i |=> !done_o && !valid_o);
endmodule

bind tree_reduce_sched tree_reduce_sched_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_load_i (cfg_load_i),
  .adv_i      (adv_i),
  .valid_o    (valid_o),
  .idx_o      (idx_o),
  .end_o      (end_o),
  .done_o     (done_o)
);

// File: tb/tree_reduce_sched_tb.sv
module tree_reduce_sched_tb;
  localparam int N = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_load = 1'b0;
  logic [7:0]   cfg_len = '0;
  logic [N-1:0] cfg_pred = '0;
  logic         cfg_rev_elem = 1'b0, cfg_rev_level = 1'b0, cfg_sel = 1'b0;
  logic [7:0]   cfg_off = '0;
  logic         adv = 1'b0;
  logic         valid_o, done_o;
  logic [7:0]   idx_o;
  logic [1:0]   end_o;

  int tests = 0, fails = 0;
  int exp_idx [0:255];
  int exp_end [0:255];
  int exp_n;

  always #5 clk = ~clk;

  tree_reduce_sched #(.MAX_LEN(N), .OUT_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_len_i(cfg_len),
    .cfg_pred_i(cfg_pred), .cfg_rev_elem_i(cfg_rev_elem), .cfg_rev_level_i(cfg_rev_level),
    .cfg_sel_right_i(cfg_sel), .cfg_offset_i(cfg_off), .adv_i(adv),
    .valid_o(valid_o), .idx_o(idx_o), .end_o(end_o), .done_o(done_o)
  );

  task automatic chk(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference schedule
  task automatic build(int len, logic [N-1:0] pred, bit re, bit rl, bit sel, int off);
    int  ixm [N];
    bit  lv  [N];
    int  nl;
    nl = 0;
    exp_n = 0;
    if (len > N) len = N;
    while ((1 << nl) < len) nl++;
    for (int e = 0; e < N; e++) begin
      ixm[e] = (re && e < len) ? len - 1 - e : e;
      lv[e]  = (e < len) && pred[ixm[e]];
    end
    for (int c = 0; c < nl; c++) begin
      int k, h, start;
      k = rl ? nl - 1 - c : c;
      h = 1 << k;
      start = exp_n;
      for (int i = 0; i < len; i += 2 * h) begin
        int o;
        o = i + h;
        if (o < len) begin
          if (lv[i] && lv[o]) begin
            exp_idx[exp_n] = ((sel ? ixm[o] : ixm[i]) + off) & 255;
            exp_end[exp_n] = 0;
            exp_n++;
          end else if (!lv[i] && lv[o]) begin
            ixm[i] = ixm[o];
            lv[i]  = 1'b1;
          end
        end
      end
      if (exp_n > start) exp_end[exp_n-1] = (c == nl - 1) ? 3 : 1;
    end
  endtask

  task automatic load(int len, logic [N-1:0] pred, bit re, bit rl, bit sel, int off);
    @(negedge clk);
    cfg_len = 8'(len); cfg_pred = pred; cfg_rev_elem = re; cfg_rev_level = rl;
    cfg_sel = sel; cfg_off = 8'(off); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic collect(int passes, string tag);
    int got = 0, p = 0, guard = 0;
    while (p < passes && guard < 4000) begin
      @(negedge clk);
      adv = 1'b0;
      guard++;
      if (done_o) begin
        chk(tag, got, exp_n, "entries per pass");
        chk(tag, int'(end_o), 0, "end flags at done");
        p++;
        got = 0;
      end else if (valid_o) begin
        if (got < exp_n) begin
          chk(tag, int'(idx_o), exp_idx[got], "index");
          chk(tag, int'(end_o), exp_end[got], "end flags");
        end else begin
          chk(tag, got + 1, exp_n, "extra entry");
        end
        got++;
        adv = 1'b1;
      end
    end
    if (p < passes) chk(tag, p, passes, "passes completed");
  endtask

  task automatic run(int len, logic [N-1:0] pred, bit re, bit rl, bit sel, int off, string tag);
    build(len, pred, re, rl, sel, off);
    load(len, pred, re, rl, sel, off);
    collect(2, tag);
  endtask

  task automatic set_exp(int n, int i0, int e0, int i1, int e1, int i2, int e2);
    exp_n = n;
    exp_idx[0] = i0; exp_end[0] = e0;
    exp_idx[1] = i1; exp_end[1] = e1;
    exp_idx[2] = i2; exp_end[2] = e2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] all1;
    all1 = '1;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, advance ignored
    @(negedge clk);
    chk("R1", int'(valid_o), 0, "valid after reset");
    chk("R1", int'(done_o), 0, "done after reset");
    chk("R1", int'(end_o), 0, "end after reset");
    chk("R1", int'(idx_o), 0, "idx after reset");
    adv = 1'b1;
    repeat (3) @(negedge clk);
    adv = 1'b0;
    chk("R1", int'(valid_o | done_o), 0, "activity before load");

    // R2/R6: full length 8, power of two
    run(8, all1, 0, 0, 0, 0, "R2");
    run(8, all1, 0, 0, 1, 0, "R4");
    // R11: non-power-two lengths and trivial lengths
    run(5, all1, 0, 0, 0, 0, "R11");
    run(7, all1, 0, 0, 1, 3, "R11");
    run(0, all1, 0, 0, 0, 0, "R11");
    run(1, all1, 0, 0, 0, 0, "R11");
    run(128, all1, 0, 0, 0, 0, "R11");

    // R5: slot 0 masked, slot 1 survives and is sourced at level 2
    set_exp(2, 2, 1, 1, 3, 0, 0);
    load(4, 128'hE, 0, 0, 0, 0);
    collect(2, "R5");
    set_exp(2, 3, 1, 2, 3, 0, 0);
    load(4, 128'hE, 0, 0, 1, 0);
    collect(1, "R5");

    // R7: reversed element order, length 4
    set_exp(3, 3, 0, 1, 1, 3, 3);
    load(4, all1, 1, 0, 0, 0);
    collect(1, "R7");

    // R8: reversed level order, length 4
    set_exp(3, 0, 1, 0, 0, 2, 3);
    load(4, all1, 0, 1, 0, 0);
    collect(1, "R8");

    // R4: offset wrap
    run(8, all1, 0, 0, 0, 250, "R4");

    // R9: hold without advance, and advance during start-up ignored
    build(8, all1, 0, 0, 0, 0);
    load(8, all1, 0, 0, 0, 0);
    adv = 1'b1;
    collect(1, "R9");
    load(8, all1, 0, 0, 0, 0);
    begin
      int g = 0;
      while (!valid_o && g < 50) begin @(negedge clk); g++; end
      repeat (4) @(negedge clk);
      chk("R9", int'(valid_o), 1, "valid held");
      chk("R9", int'(idx_o), exp_idx[0], "index held");
    end

    // R12: reload in the middle of a schedule
    for (int t = 0; t < 3; t++) begin
      @(negedge clk); adv = 1'b0;
      if (valid_o) adv = 1'b1;
    end
    @(negedge clk); adv = 1'b0;
    build(6, all1, 1, 0, 1, 10);
    load(6, all1, 1, 0, 1, 10);
    chk("R12", int'(valid_o | done_o), 0, "outputs idle after reload");
    collect(1, "R12");

    // R3: random configurations
    for (int r = 0; r < 40; r++) begin
      logic [N-1:0] pr;
      int len, md;
      len = $urandom_range(0, 128);
      md  = $urandom_range(0, 2);
      for (int w = 0; w < N / 32; w++) begin
        logic [31:0] a;
        a = $urandom();
        if (md == 1) a = a & $urandom();
        if (md == 2) a = a | $urandom();
        pr[w*32 +: 32] = a;
      end
      run(len, pr, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), $urandom_range(0, 255), "R3");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule